// File: doc/BRIEF.md
# Bit-Programmable GPIO Port with Edge Interrupts

This block is a general-purpose I/O port whose width is a parameter (eight bits by default, two bits for a narrow instance). Each bit is set up on its own through a set of byte-wide registers: its direction, its output value, whether the pad is driven by the port or by a peripheral, whether its pull resistor is enabled, and an interrupt with a per-bit choice of edge. Pad levels pass through a two-flop synchronizer. The synchronized levels feed the input register, the peripheral side and a per-bit edge detector.

A detected edge sets a sticky flag bit whether or not that bit's interrupt is enabled. The single interrupt request is high while any bit has both its flag and its enable set. Software can write the flag register directly, both to clear flags and to raise interrupts from software. The pull resistor and the analog pad are outside the block; only the output value, the drive enable and the pull enable go to the pad model.

Top module: `gpio_port`

## Requirements
- R1: After reset every writable register reads 0, and irq_o, pin_oe_o and pull_en_o are 0.
- R2: Register offsets on addr_i are 0 input, 1 output, 2 direction, 3 flag, 4 edge select, 5 interrupt enable, 6 function select, 7 pull enable. A write with we_i high takes effect at the next clock edge. Every register except offset 0 reads back what was last written. A write to offset 0 has no effect.
- R3: Offset 0 reads the pin level as sampled two clock edges earlier, through two flops.
- R4: pin_oe_o follows the direction register bit by bit (1 drives the pad). pull_en_o follows the pull enable register bit by bit.
- R5: A function-select bit of 1 routes periph_i to pin_o for that bit; 0 routes the output register. periph_o always carries the synchronized pin levels.
- R6: An edge-select bit of 0 sets that flag on a synchronized rising edge, and 1 sets it on a falling edge. The opposite edge leaves the flag alone. The flag reads 1 after the third clock edge that follows the pin change.
- R7: Flags are set regardless of the enable. irq_o is 1 exactly when some bit has both its flag and its enable set.
- R8: A write to offset 3 replaces the flags with the written value (0 clears, 1 sets). If an edge hits a bit in the same cycle as the write, that bit ends up set.
- R9: A two-bit instance of the same module behaves the same way on its two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register offset |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | WIDTH | Read data for addr_i (combinational) |
| pin_i | input | WIDTH | Pad input levels |
| pin_o | output | WIDTH | Pad output values |
| pin_oe_o | output | WIDTH | Pad drive enables |
| pull_en_o | output | WIDTH | Pull resistor enables |
| periph_i | input | WIDTH | Peripheral output values |
| periph_o | output | WIDTH | Synchronized pin levels to the peripheral |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench aims at these cases:
- An edge that lands in the same cycle as a flag write. A design that lets the write win loses that interrupt.
- The edge that was not selected. A design with the edge-select sense swapped sets flags on the wrong transition.
- Flags raised while the enable is clear. A design that gates flag setting with the enable misses interrupts that are enabled later.
- Writes to the read-only input offset, which a faulty decoder would store into a neighbouring register.
- Exact synchronizer latency. A missing or extra flop shifts the input value and the flag timing by a cycle against the reference model.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    OFF_IN   = 3'd0,
    OFF_OUT  = 3'd1,
    OFF_DIR  = 3'd2,
    OFF_FLAG = 3'd3,
    OFF_EDGE = 3'd4,
    OFF_IE   = 3'd5,
    OFF_FSEL = 3'd6,
    OFF_PULL = 3'd7
  } reg_off_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] level_i,
  input  logic [WIDTH-1:0] fall_sel_i,
  input  logic             flag_we_i,
  input  logic [WIDTH-1:0] flag_wdata_i,
  output logic [WIDTH-1:0] hit_o,
  output logic [WIDTH-1:0] flag_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] flag_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic rise, fall;
    assign rise     = level_i[b] & ~prev_q[b];
    assign fall     = ~level_i[b] & prev_q[b];
    assign hit_o[b] = fall_sel_i[b] ? fall : rise;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[b] <= 1'b0;
        flag_q[b] <= 1'b0;
      end else begin
        prev_q[b] <= level_i[b];
        // edge has priority over a same-cycle software clear
        if (hit_o[b])       flag_q[b] <= 1'b1;
        else if (flag_we_i) flag_q[b] <= flag_wdata_i[b];
      end
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  out_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  edge_q,
  output logic [WIDTH-1:0]  ie_q,
  output logic [WIDTH-1:0]  fsel_q,
  output logic [WIDTH-1:0]  pull_q
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '0;
      edge_q <= '0;
      ie_q   <= '0;
      fsel_q <= '0;
      pull_q <= '0;
    end else if (we_i) begin
      unique case (reg_off_e'(addr_i))
        OFF_OUT:  out_q  <= wdata_i;
        OFF_DIR:  dir_q  <= wdata_i;
        OFF_EDGE: edge_q <= wdata_i;
        OFF_IE:   ie_q   <= wdata_i;
        OFF_FSEL: fsel_q <= wdata_i;
        OFF_PULL: pull_q <= wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pin_o,
  output logic [WIDTH-1:0]  pin_oe_o,
  output logic [WIDTH-1:0]  pull_en_o,
  input  logic [WIDTH-1:0]  periph_i,
  output logic [WIDTH-1:0]  periph_o,
  output logic              irq_o
);
  logic [WIDTH-1:0] level;
  logic [WIDTH-1:0] out_q, dir_q, edge_q, ie_q, fsel_q, pull_q;
  logic [WIDTH-1:0] flag_q, hit;
  logic             flag_we;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (level)
  );

  gpio_ctrl_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .out_q  (out_q),
    .dir_q  (dir_q),
    .edge_q (edge_q),
    .ie_q   (ie_q),
    .fsel_q (fsel_q),
    .pull_q (pull_q)
  );

  assign flag_we = we_i && (reg_off_e'(addr_i) == OFF_FLAG);

  gpio_edge_flags #(.WIDTH(WIDTH)) u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .level_i     (level),
    .fall_sel_i  (edge_q),
    .flag_we_i   (flag_we),
    .flag_wdata_i(wdata_i),
    .hit_o       (hit),
    .flag_o      (flag_q)
  );

  always_comb begin
    unique case (reg_off_e'(addr_i))
      OFF_IN:   rdata_o = level;
      OFF_OUT:  rdata_o = out_q;
      OFF_DIR:  rdata_o = dir_q;
      OFF_FLAG: rdata_o = flag_q;
      OFF_EDGE: rdata_o = edge_q;
      OFF_IE:   rdata_o = ie_q;
      OFF_FSEL: rdata_o = fsel_q;
      default:  rdata_o = pull_q;
    endcase
  end

  assign pin_o     = (fsel_q & periph_i) | (~fsel_q & out_q);
  assign pin_oe_o  = dir_q;
  assign pull_en_o = pull_q;
  assign periph_o  = level;
  assign irq_o     = |(flag_q & ie_q);
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [2:0]       addr_i,
  input logic [WIDTH-1:0] wdata_i,
  input logic [WIDTH-1:0] pin_i,
  input logic [WIDTH-1:0] pin_oe_o,
  input logic [WIDTH-1:0] periph_o,
  input logic             irq_o,
  input logic [WIDTH-1:0] flag_q,
  input logic [WIDTH-1:0] hit,
  input logic [WIDTH-1:0] ie_q
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  // R2
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd2) |=> (pin_oe_o == $past(wdata_i)));

  // R3
  sync_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd3) |-> (periph_o == $past(pin_i, 2)));

  // R8
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == 3'd3) |=> (($past(flag_q) & ~flag_q) == '0));

  // R6
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == 3'd3) |=> ((flag_q & ~$past(flag_q) & ~$past(hit)) == '0));

  // R8
  flag_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd3) |=> (flag_q == ($past(wdata_i) | $past(hit))));

  // R7
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_q == '0) |-> !irq_o);
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .pin_i   (pin_i),
  .pin_oe_o(pin_oe_o),
  .periph_o(periph_o),
  .irq_o   (irq_o),
  .flag_q  (flag_q),
  .hit     (hit),
  .ie_q    (ie_q)
);

// File: tb/gpio_port_test.sv
module gpio_port_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0, pin_i = '0, periph_i = '0;
  logic [7:0] rdata_o, pin_o, pin_oe_o, pull_en_o, periph_o;
  logic       irq_o;

  logic       n_we = 1'b0;
  logic [2:0] n_addr = '0;
  logic [1:0] n_wdata = '0, n_pin = '0, n_periph = '0;
  logic [1:0] n_rdata, n_pin_o, n_oe, n_pull, n_periph_o;
  logic       n_irq;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  gpio_port #(.WIDTH(8)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
    .pull_en_o(pull_en_o), .periph_i(periph_i), .periph_o(periph_o), .irq_o(irq_o));

  gpio_port #(.WIDTH(2)) uut_narrow (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(n_we), .addr_i(n_addr), .wdata_i(n_wdata),
    .rdata_o(n_rdata), .pin_i(n_pin), .pin_o(n_pin_o), .pin_oe_o(n_oe),
    .pull_en_o(n_pull), .periph_i(n_periph), .periph_o(n_periph_o), .irq_o(n_irq));

  // behavioural reference model, indexed by offset
  logic [7:0] m_reg [8];
  logic [7:0] m_s1, m_s2, m_prev;

  function automatic logic [7:0] m_read(input int a);
    return (a == 0) ? m_s2 : m_reg[a];
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < 8; a++) m_reg[a] = '0;
      m_s1 = '0; m_s2 = '0; m_prev = '0;
    end else begin
      logic [7:0] hits;
      for (int i = 0; i < 8; i++) begin
        if (m_reg[4][i] == 1'b0) hits[i] = m_s2[i] && !m_prev[i];
        else                     hits[i] = !m_s2[i] && m_prev[i];
      end
      if (we_i && addr_i != 3'd0) m_reg[addr_i] = wdata_i;
      m_reg[3] = m_reg[3] | hits;
      m_prev = m_s2;
      m_s2 = m_s1;
      m_s1 = pin_i;
    end
  end

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      logic [7:0] exp_pin;
      string rq;
      exp_pin = (m_reg[6] & periph_i) | (~m_reg[6] & m_reg[1]);
      rq = (addr_i == 3'd0) ? "R3" : (addr_i == 3'd3) ? "R6" : "R2";
      check(rdata_o === m_read(int'(addr_i)), rq, rdata_o, m_read(int'(addr_i)));
      check(pin_oe_o === m_reg[2], "R4", pin_oe_o, m_reg[2]);
      check(pull_en_o === m_reg[7], "R4", pull_en_o, m_reg[7]);
      check(pin_o === exp_pin, "R5", pin_o, exp_pin);
      check(periph_o === m_s2, "R5", periph_o, m_s2);
      check(irq_o === ((m_reg[3] & m_reg[5]) != 0), "R7", {7'd0, irq_o},
            {7'd0, (m_reg[3] & m_reg[5]) != 0});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i); we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); we_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge clk_i); addr_i = a; #1;
    check(rdata_o === exp, req, rdata_o, exp);
  endtask

  task automatic n_wr(input logic [2:0] a, input logic [1:0] d);
    @(negedge clk_i); n_we = 1'b1; n_addr = a; n_wdata = d;
    @(negedge clk_i); n_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset values while reset is held
    for (int a = 0; a < 8; a++) begin
      addr_i = 3'(a); #1;
      check(rdata_o === 8'h00, "R1", rdata_o, 8'h00);
    end
    check(irq_o === 1'b0 && pin_oe_o === 8'h00 && pull_en_o === 8'h00, "R1",
          {irq_o, 7'd0}, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;

    // R2: readback on every writable offset, ignored write to offset 0
    for (int a = 1; a < 8; a++) begin
      if (a != 3) begin
        wr(3'(a), 8'hA5 ^ 8'(a));
        rd_chk(3'(a), 8'hA5 ^ 8'(a), "R2");
      end
    end
    wr(3'd0, 8'hFF);
    rd_chk(3'd0, 8'h00, "R2");
    rd_chk(3'd1, 8'hA4, "R2");

    // R4, R5: direction, pull, function select routing
    wr(3'd2, 8'h3C); wr(3'd7, 8'hC3);
    wr(3'd1, 8'h0F); wr(3'd6, 8'hF0);
    @(negedge clk_i); periph_i = 8'h99; #1;
    check(pin_o === 8'h9F, "R5", pin_o, 8'h9F);
    check(pin_oe_o === 8'h3C, "R4", pin_oe_o, 8'h3C);

    // R3: two-flop latency on the input offset
    wr(3'd5, 8'h00); wr(3'd3, 8'h00);
    @(negedge clk_i); addr_i = 3'd0; pin_i = 8'h5A;
    @(negedge clk_i); check(rdata_o === 8'h00, "R3", rdata_o, 8'h00);
    @(negedge clk_i); check(rdata_o === 8'h5A, "R3", rdata_o, 8'h5A);
    @(negedge clk_i); pin_i = 8'h00;
    repeat (4) @(negedge clk_i);
    wr(3'd3, 8'h00);

    // R6, R7: rising on low nibble, falling on high nibble, enables clear
    wr(3'd4, 8'hF0);
    @(negedge clk_i); pin_i = 8'hFF;
    repeat (4) @(negedge clk_i);
    rd_chk(3'd3, 8'h0F, "R6");
    check(irq_o === 1'b0, "R7", {7'd0, irq_o}, 8'h00);
    @(negedge clk_i); pin_i = 8'h00;
    repeat (4) @(negedge clk_i);
    rd_chk(3'd3, 8'hFF, "R6");
    wr(3'd5, 8'h01);
    check(irq_o === 1'b1, "R7", {7'd0, irq_o}, 8'h01);

    // R8: software clear and software set
    wr(3'd3, 8'h00);
    check(irq_o === 1'b0, "R8", {7'd0, irq_o}, 8'h00);
    wr(3'd5, 8'h80); wr(3'd3, 8'h80);
    check(irq_o === 1'b1, "R8", {7'd0, irq_o}, 8'h01);
    wr(3'd3, 8'h00);

    // R8: edge in the same cycle as a clearing write wins
    wr(3'd4, 8'h00);
    @(negedge clk_i); pin_i = 8'h01;
    @(negedge clk_i);
    @(negedge clk_i); we_i = 1'b1; addr_i = 3'd3; wdata_i = 8'h00;
    @(negedge clk_i); we_i = 1'b0; #1;
    check(rdata_o === 8'h01, "R8", rdata_o, 8'h01);

    // randomized traffic against the model
    for (int n = 0; n < 600; n++) begin
      @(negedge clk_i);
      pin_i = 8'($urandom);
      periph_i = 8'($urandom);
      addr_i = 3'($urandom);
      we_i = ($urandom % 4) == 0;
      wdata_i = 8'($urandom);
    end
    @(negedge clk_i); we_i = 1'b0;

    // R9: two-bit instance
    n_wr(3'd2, 2'b10);
    check(n_oe === 2'b10, "R9", {6'd0, n_oe}, 8'h02);
    n_wr(3'd4, 2'b10); n_wr(3'd5, 2'b01);
    @(negedge clk_i); n_pin = 2'b11;
    repeat (4) @(negedge clk_i);
    n_addr = 3'd3; #1;
    check(n_rdata === 2'b01, "R9", {6'd0, n_rdata}, 8'h01);
    check(n_irq === 1'b1, "R9", {7'd0, n_irq}, 8'h01);
    @(negedge clk_i); n_pin = 2'b00;
    repeat (4) @(negedge clk_i); #1;
    check(n_rdata === 2'b11, "R9", {6'd0, n_rdata}, 8'h03);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule